// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block sits beside a CAN protocol core and turns the core's event strobes and level statuses into two active-high interrupt request lines. The first line, `irq_fifo`, serves the receive FIFO: a non-empty pending-message count, a FIFO-full condition and a FIFO overrun. The second line, `irq_sts`, combines three things: transmit mailboxes that have finished, error conditions, and a wakeup seen on the bus while the controller sleeps.

Every cause has its own enable bit. The error causes are error-warning, error-passive, bus-off and a non-zero last-error code. When enabled, any of them sets one sticky error summary flag. That flag reaches `irq_sts` only when a master error enable is also set. A wakeup is a recessive-to-dominant transition on the receive pin. The pin is first passed through a synchronizer, and the detector is armed only while `sleep` is high.

Software reaches the block through a small register port. It can write and read the enable word, read the sticky flags, and clear any flag by writing 1 to its bit. The bit bus timing, frame handling, error counters and FIFO storage all belong to the core.

Top module: `can_irq_hub`

## Requirements
- R1: After reset, both interrupt lines are low and every enable and flag bit reads 0.
- R2: When the pending-message count is non-zero and enable bit 0 is set, `irq_fifo` is high from the clock edge after the one that sampled the count. It is cleared the same way once the count returns to 0, unless another enabled FIFO cause is present.
- R3: Flag bit 0 (full) is set on a rising edge of `fifo_full`, and flag bit 1 (overrun) is set on each `fifo_ovr` strobe. These reach `irq_fifo` through enable bit 1 and enable bit 2 respectively.
- R4: A `tx_done[i]` strobe sets flag bit 5+i. The OR of all mailbox flags reaches `irq_sts` through the single enable bit 3.
- R5: The error summary flag (flag bit 3) is set by any of the following, each gated by its own enable: a rising edge of `err_warn` (enable bit 4), a rising edge of `err_pasv` (bit 5), a rising edge of `bus_off` (bit 6), or a non-zero `lec_code` (bit 7). Flag bit 4 is set by any non-zero `lec_code`, whatever the enables. The summary flag drives `irq_sts` only while master enable bit 8 is set.
- R6: An error level that stays high after its first rising edge does not set the summary flag again once software has cleared it.
- R7: Flag bit 2 (wakeup) is set by a high-to-low transition of the synchronized `rx_pin` while `sleep` is high. The transition is ignored while `sleep` is low. The wakeup flag reaches `irq_sts` through enable bit 9.
- R8: Writing to address 1 clears every flag bit written as 1 and leaves bits written as 0 unchanged. If a flag's set event arrives in the same cycle as its clear, the flag ends up set.
- R9: The interrupt lines are registered levels. Each stays high while any enabled cause remains, and falls one edge after the last cause is cleared or disabled.
- R10: Address 0 writes and reads the enable word, and address 1 reads the flags. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | CNT_W | Receive FIFO pending-message count |
| fifo_full | input | 1 | Receive FIFO full level |
| fifo_ovr | input | 1 | Receive FIFO overrun strobe |
| tx_done | input | NUM_MB | Per-mailbox transmit-complete strobes |
| err_warn | input | 1 | Error-warning level |
| err_pasv | input | 1 | Error-passive level |
| bus_off | input | 1 | Bus-off level |
| lec_code | input | LEC_W | Last error code, non-zero for one cycle per error |
| sleep | input | 1 | Controller is in sleep; arms wakeup detection |
| rx_pin | input | 1 | Asynchronous CAN receive pin, 1 = recessive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq_fifo | output | 1 | Receive FIFO interrupt request |
| irq_sts | output | 1 | Transmit/error/status interrupt request |

## Verification
The results arrive at different times:
- A non-zero message count shows on `irq_fifo` one edge after it is sampled.
- A strobe or level edge sets its flag on the sampling edge, and the interrupt line follows one edge later.
- A falling edge on `rx_pin` sets the wakeup flag SYNC_N+1 edges after it occurs, and `irq_sts` follows one edge after that.
- An enable write or a clear acts on the lines one edge after the write edge.

The bench drives all inputs at the falling clock edge and advances its expected-state functions at each rising edge. It compares the interrupt lines and the read data at the next falling edge, so every check lands in the cycle its latency predicts.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    // Enable word bit positions (register address 0)
    localparam int EN_MSG  = 0;
    localparam int EN_FULL = 1;
    localparam int EN_OVR  = 2;
    localparam int EN_TX   = 3;
    localparam int EN_WARN = 4;
    localparam int EN_PASV = 5;
    localparam int EN_BOFF = 6;
    localparam int EN_LEC  = 7;
    localparam int EN_ERR  = 8;
    localparam int EN_WAKE = 9;
    localparam int EN_W    = 10;

    // Flag word bit positions (register address 1); mailbox flags start at FL_TX0
    localparam int FL_FULL = 0;
    localparam int FL_OVR  = 1;
    localparam int FL_WAKE = 2;
    localparam int FL_ERR  = 3;
    localparam int FL_LEC  = 4;
    localparam int FL_TX0  = 5;

    // Register addresses
    localparam int ADDR_EN   = 0;
    localparam int ADDR_FLAG = 1;

endpackage

// File: rtl/can_irq_wake.sv
module can_irq_wake #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic sleep,
    output logic wake_evt
);
    typedef struct packed {
        logic [SYNC_N-1:0] sh;
        logic              prev;
    } wake_st_t;

    wake_st_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[SYNC_N-2:0], rx_pin};
        d.prev = q.sh[SYNC_N-1];
    end

    // recessive-to-dominant transition on the synchronized pin
    assign wake_evt = sleep && q.prev && !q.sh[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh   <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/can_irq_errsrc.sv
module can_irq_errsrc #(
    parameter int LEC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_warn,
    input  logic             err_pasv,
    input  logic             bus_off,
    input  logic [LEC_W-1:0] lec_code,
    input  logic             en_warn,
    input  logic             en_pasv,
    input  logic             en_boff,
    input  logic             en_lec,
    output logic             err_evt,
    output logic             lec_evt
);
    typedef struct packed {
        logic warn;
        logic pasv;
        logic boff;
    } lvl_st_t;

    lvl_st_t q, d;
    logic    warn_rise, pasv_rise, boff_rise;

    always_comb begin
        d.warn = err_warn;
        d.pasv = err_pasv;
        d.boff = bus_off;
    end

    assign warn_rise = err_warn && !q.warn;
    assign pasv_rise = err_pasv && !q.pasv;
    assign boff_rise = bus_off  && !q.boff;
    assign lec_evt   = (lec_code != '0);
    assign err_evt   = (en_warn && warn_rise) || (en_pasv && pasv_rise) ||
                       (en_boff && boff_rise) || (en_lec && lec_evt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/can_irq_hub.sv
module can_irq_hub
    import can_irq_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int CNT_W  = 2,
    parameter int LEC_W  = 3,
    parameter int SYNC_N = 2,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              fifo_full,
    input  logic              fifo_ovr,
    input  logic [NUM_MB-1:0] tx_done,
    input  logic              err_warn,
    input  logic              err_pasv,
    input  logic              bus_off,
    input  logic [LEC_W-1:0]  lec_code,
    input  logic              sleep,
    input  logic              rx_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_fifo,
    output logic              irq_sts
);
    localparam int FLAG_W = FL_TX0 + NUM_MB;

    typedef struct packed {
        logic [EN_W-1:0]   en;
        logic [FLAG_W-1:0] flag;
        logic              full_prev;
        logic              irq_f;
        logic              irq_s;
    } hub_st_t;

    hub_st_t q, d;

    logic              wake_evt, err_evt, lec_evt;
    logic              wr_en, wr_flag;
    logic [FLAG_W-1:0] set_v, clr_v;
    logic [EN_W-1:0]   en_q;
    logic [FLAG_W-1:0] flag_q;

    assign en_q   = q.en;
    assign flag_q = q.flag;

    can_irq_wake #(.SYNC_N(SYNC_N)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pin   (rx_pin),
        .sleep    (sleep),
        .wake_evt (wake_evt)
    );

    can_irq_errsrc #(.LEC_W(LEC_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_warn (err_warn),
        .err_pasv (err_pasv),
        .bus_off  (bus_off),
        .lec_code (lec_code),
        .en_warn  (q.en[EN_WARN]),
        .en_pasv  (q.en[EN_PASV]),
        .en_boff  (q.en[EN_BOFF]),
        .en_lec   (q.en[EN_LEC]),
        .err_evt  (err_evt),
        .lec_evt  (lec_evt)
    );

    assign wr_en   = reg_wr && (reg_addr == ADDR_W'(ADDR_EN));
    assign wr_flag = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG));

    always_comb begin
        set_v                      = '0;
        set_v[FL_FULL]             = fifo_full && !q.full_prev;
        set_v[FL_OVR]              = fifo_ovr;
        set_v[FL_WAKE]             = wake_evt;
        set_v[FL_ERR]              = err_evt;
        set_v[FL_LEC]              = lec_evt;
        set_v[FLAG_W-1:FL_TX0]     = tx_done;
        clr_v = wr_flag ? reg_wdata[FLAG_W-1:0] : '0;
    end

    always_comb begin
        d           = q;
        d.flag      = (q.flag & ~clr_v) | set_v;   // set beats clear
        if (wr_en) d.en = reg_wdata[EN_W-1:0];
        d.full_prev = fifo_full;
        d.irq_f     = (q.en[EN_MSG]  && (rx_count != '0)) ||
                      (q.en[EN_FULL] && q.flag[FL_FULL]) ||
                      (q.en[EN_OVR]  && q.flag[FL_OVR]);
        d.irq_s     = (q.en[EN_TX]   && (|q.flag[FLAG_W-1:FL_TX0])) ||
                      (q.en[EN_ERR]  && q.flag[FL_ERR]) ||
                      (q.en[EN_WAKE] && q.flag[FL_WAKE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_EN))        reg_rdata[EN_W-1:0]   = q.en;
        else if (reg_addr == ADDR_W'(ADDR_FLAG)) reg_rdata[FLAG_W-1:0] = q.flag;
    end

    assign irq_fifo = q.irq_f;
    assign irq_sts  = q.irq_s;
endmodule

// File: rtl/can_irq_hub_chk.sv
module can_irq_hub_chk
    import can_irq_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int CNT_W  = 2,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    localparam int FLAG_W = FL_TX0 + NUM_MB
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  rx_count,
    input logic              fifo_ovr,
    input logic [NUM_MB-1:0] tx_done,
    input logic              sleep,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_fifo,
    input logic              irq_sts,
    input logic [EN_W-1:0]   en_q,
    input logic [FLAG_W-1:0] flag_q
);
    logic clr_ovr;
    assign clr_ovr = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG)) && reg_wdata[FL_OVR];

    assert_msg_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[EN_MSG] && (rx_count != '0)) |=> irq_fifo);

    assert_tx_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done[0] |=> flag_q[FL_TX0]);

    assert_err_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FL_ERR] && en_q[EN_ERR]) |=> irq_sts);

    assert_wake_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[FL_WAKE]) |-> $past(sleep));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovr |=> flag_q[FL_OVR]);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !fifo_ovr) |=> !flag_q[FL_OVR]);
endmodule

bind can_irq_hub can_irq_hub_chk #(
    .NUM_MB (NUM_MB),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_count  (rx_count),
    .fifo_ovr  (fifo_ovr),
    .tx_done   (tx_done),
    .sleep     (sleep),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_fifo  (irq_fifo),
    .irq_sts   (irq_sts),
    .en_q      (en_q),
    .flag_q    (flag_q)
);

// File: tb/can_irq_hub_test.sv
`timescale 1ns/1ps
module can_irq_hub_test;
    import can_irq_pkg::*;

    localparam int NUM_MB = 3;
    localparam int CNT_W  = 2;
    localparam int LEC_W  = 3;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;
    localparam int FLAG_W = FL_TX0 + NUM_MB;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              fifo_full = 0, fifo_ovr = 0;
    logic [NUM_MB-1:0] tx_done = '0;
    logic              err_warn = 0, err_pasv = 0, bus_off = 0;
    logic [LEC_W-1:0]  lec_code = '0;
    logic              sleep = 0, rx_pin = 1;
    logic              reg_wr = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_fifo, irq_sts;

    can_irq_hub #(.NUM_MB(NUM_MB), .CNT_W(CNT_W), .LEC_W(LEC_W), .SYNC_N(2),
                  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .fifo_full(fifo_full),
        .fifo_ovr(fifo_ovr), .tx_done(tx_done), .err_warn(err_warn),
        .err_pasv(err_pasv), .bus_off(bus_off), .lec_code(lec_code),
        .sleep(sleep), .rx_pin(rx_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_fifo(irq_fifo),
        .irq_sts(irq_sts));

    // expected state, advanced from the requirements
    logic [EN_W-1:0]   m_en;
    logic [FLAG_W-1:0] m_flag;
    logic              m_fp, m_wp, m_pp, m_bp, m_prev, m_irqf, m_irqs;
    logic [1:0]        m_sh;

    int    checks = 0, fails = 0;
    bit    done = 0;
    string tag = "R1";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_rdata(logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] r = '0;
        if (a == ADDR_W'(ADDR_EN))        r[EN_W-1:0]   = m_en;
        else if (a == ADDR_W'(ADDR_FLAG)) r[FLAG_W-1:0] = m_flag;
        return r;
    endfunction

    task automatic model_reset();
        m_en = '0; m_flag = '0; m_fp = 0; m_wp = 0; m_pp = 0; m_bp = 0;
        m_prev = 1; m_sh = 2'b11; m_irqf = 0; m_irqs = 0;
    endtask

    task automatic model_edge();
        logic [FLAG_W-1:0] set_v, clr_v;
        logic nf, ns;
        nf = (m_en[EN_MSG] && rx_count != 0) || (m_en[EN_FULL] && m_flag[FL_FULL]) ||
             (m_en[EN_OVR] && m_flag[FL_OVR]);
        ns = (m_en[EN_TX] && (|m_flag[FLAG_W-1:FL_TX0])) ||
             (m_en[EN_ERR] && m_flag[FL_ERR]) || (m_en[EN_WAKE] && m_flag[FL_WAKE]);
        set_v = '0;
        set_v[FL_FULL] = fifo_full && !m_fp;
        set_v[FL_OVR]  = fifo_ovr;
        set_v[FL_WAKE] = sleep && m_prev && !m_sh[1];
        set_v[FL_ERR]  = (m_en[EN_WARN] && err_warn && !m_wp) ||
                         (m_en[EN_PASV] && err_pasv && !m_pp) ||
                         (m_en[EN_BOFF] && bus_off && !m_bp) ||
                         (m_en[EN_LEC] && lec_code != 0);
        set_v[FL_LEC]  = lec_code != 0;
        set_v[FLAG_W-1:FL_TX0] = tx_done;
        clr_v = (reg_wr && reg_addr == ADDR_W'(ADDR_FLAG)) ? reg_wdata[FLAG_W-1:0] : '0;
        m_flag = (m_flag & ~clr_v) | set_v;
        if (reg_wr && reg_addr == ADDR_W'(ADDR_EN)) m_en = reg_wdata[EN_W-1:0];
        m_fp = fifo_full; m_wp = err_warn; m_pp = err_pasv; m_bp = bus_off;
        m_prev = m_sh[1]; m_sh = {m_sh[0], rx_pin};
        m_irqf = nf; m_irqs = ns;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("irq_fifo", irq_fifo, m_irqf);
        chk("irq_sts", irq_sts, m_irqs);
        chk("reg_rdata", reg_rdata, exp_rdata(reg_addr));
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        cycle();
        reg_wr = 0;
    endtask

    task automatic peek(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, string what);
        reg_addr = a;
        #1;
        chk(what, reg_rdata, exp);
    endtask

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tag = "R1";
        chk("irq_fifo", irq_fifo, 0);
        chk("irq_sts", irq_sts, 0);
        peek(0, '0, "enables");
        peek(1, '0, "flags");

        // R2: message count drives irq_fifo one edge later
        tag = "R2";
        wr(0, 16'(1 << EN_MSG));
        rx_count = 2'd1;
        cycle();
        chk("irq_fifo after count", irq_fifo, 1);
        rx_count = 2'd0;
        cycle();
        chk("irq_fifo after empty", irq_fifo, 0);

        // R7: falling edge ignored while awake, flagged while asleep
        tag = "R7";
        wr(0, 16'(1 << EN_WAKE));
        sleep = 0; rx_pin = 0;
        repeat (4) cycle();
        rx_pin = 1;
        repeat (3) cycle();
        peek(1, '0, "wake flag while awake");
        sleep = 1; rx_pin = 0;
        repeat (4) cycle();
        peek(1, 16'(1 << FL_WAKE), "wake flag while asleep");
        chk("irq_sts wake", irq_sts, 1);
        rx_pin = 1;
        repeat (3) cycle();

        // R8: clear all while overrun strobe arrives -> overrun stays set
        tag = "R8";
        fifo_ovr = 1;
        wr(1, '1);
        fifo_ovr = 0;
        peek(1, 16'(1 << FL_OVR), "set wins over clear");

        // R6: held warning level does not re-raise the summary flag
        tag = "R6";
        wr(0, 16'((1 << EN_WARN) | (1 << EN_ERR)));
        err_warn = 1;
        repeat (2) cycle();
        chk("irq_sts on warning", irq_sts, 1);
        wr(1, 16'(1 << FL_ERR));
        repeat (5) cycle();
        peek(1, 16'(1 << FL_OVR), "summary after clear with level held");
        chk("irq_sts after clear", irq_sts, 0);
        err_warn = 0;
        cycle();

        // R10: unmapped addresses
        tag = "R10";
        wr(2, '1);
        wr(3, '1);
        peek(2, '0, "addr 2 reads 0");
        peek(3, '0, "addr 3 reads 0");
        peek(0, 16'((1 << EN_WARN) | (1 << EN_ERR)), "enables unchanged");

        // R9 and R4: mailbox flag holds the line until cleared
        tag = "R9 R4";
        wr(0, 16'(1 << EN_TX));
        tx_done = 3'b010;
        cycle();
        tx_done = '0;
        repeat (4) cycle();
        chk("irq_sts held", irq_sts, 1);
        wr(1, 16'(1 << (FL_TX0 + 1)));
        cycle();
        chk("irq_sts released", irq_sts, 0);

        // R3: full edge via its enable
        tag = "R3";
        wr(0, 16'(1 << EN_FULL));
        fifo_full = 1;
        repeat (2) cycle();
        chk("irq_fifo full", irq_fifo, 1);
        fifo_full = 0;

        // R5: non-zero error code with master off then on
        tag = "R5";
        wr(1, '1);
        wr(0, 16'(1 << EN_LEC));
        lec_code = 3'd3;
        cycle();
        lec_code = '0;
        repeat (2) cycle();
        chk("irq_sts without master", irq_sts, 0);
        wr(0, 16'((1 << EN_LEC) | (1 << EN_ERR)));
        cycle();
        chk("irq_sts with master", irq_sts, 1);

        // constrained random mix
        tag = "R2 R3 R4 R5 R7 R8 R9 R10";
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 4000; i++) begin
            reg_wr    = ($urandom_range(0, 7) == 0);
            reg_addr  = ADDR_W'($urandom_range(0, 3));
            reg_wdata = DATA_W'($urandom);
            rx_count  = ($urandom_range(0, 1) == 0) ? '0 : CNT_W'($urandom);
            fifo_ovr  = ($urandom_range(0, 15) == 0);
            for (int k = 0; k < NUM_MB; k++) tx_done[k] = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 31) == 0) fifo_full = ~fifo_full;
            if ($urandom_range(0, 31) == 0) err_warn = ~err_warn;
            if ($urandom_range(0, 31) == 0) err_pasv = ~err_pasv;
            if ($urandom_range(0, 31) == 0) bus_off = ~bus_off;
            if ($urandom_range(0, 63) == 0) sleep = ~sleep;
            if ($urandom_range(0, 7) == 0) rx_pin = ~rx_pin;
            lec_code  = ($urandom_range(0, 15) == 0) ? LEC_W'($urandom_range(1, 7)) : '0;
            cycle();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule